// File: doc/BRIEF.md
# Two-Wire Debug Link Bit Engine (Host Side)

This block is the host-side bit engine of a two-wire serial debug link. One wire is a clock that only the host generates. The other is a single data line that both ends share. The target has no clock of its own, so every one of its actions follows an edge that the host produces.

The engine divides the system clock down to the link clock. It shifts command bits out on the data line or collects bits from it, and it inserts idle turnaround periods whenever ownership of the line changes hands. A higher layer issues one command at a time. Each command gives a bit count, a direction and a data word, and is started with a start pulse. The higher layer then waits for the done pulse, which arrives together with the captured word for a read. Building packets, checking parity and handling acknowledgements are left to that higher layer.

Timing on the line follows from the target being clock-less:
- The host changes its outgoing bit when the clock falls and holds it through the whole high half, so the target can sample it on the rising edge.
- The host samples the target's bit at the end of the low half, just before its own rising edge, because the target changes its output right after each rising edge.

Top module: `swd_wire_engine`

## Requirements
- R1: After reset `swclk_o`, `busy_o` and `done_o` are 0, `rdata_o` is 0, and `swdoe_o` is 1, because the host owns the line.
- R2: Each link clock period is a low half followed by a high half. Each half lasts `half_i` system clocks, with a value of 0 treated as 1. `swclk_o` is 0 whenever the engine is idle.
- R3: In a write command (`rd_i`=0), bit k of `wdata_i` goes out in data period k, so bit 0 is first. The bit changes only at the start of a low half and stays stable through the high half.
- R4: In a read command (`rd_i`=1), `swdi_i` is sampled in the last system clock of the low half of data period k and placed in `rdata_o[k]`. Bits at or above the bit count read as 0. `rdata_o` takes the new word in the same cycle that `done_o` is 1.
- R5: Line ownership after reset is the host. When a command's direction differs from the previous owner, the engine first inserts TURN_CYC full clock periods with `swdoe_o`=0. `swdoe_o` drops at the start of the first of these periods.
- R6: During the data periods of a read, `swdoe_o` is 0, and it stays 0 while idle after a read. During the data periods of a write, `swdoe_o` is 1, and it stays 1 while idle after a write.
- R7: `busy_o` rises on the edge that accepts `start_i` and stays high for 2·H·(T+N) system clocks. H is the effective half period, T the turnaround count and N the bit count. `done_o` is high for exactly one cycle, in the cycle where `busy_o` has just fallen.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: the running command's bits and timing are unchanged, and no extra `done_o` is produced.
- R9: The bit count `nbits_i` may be any value from 1 to 64, and both extremes complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse, accepted when idle |
| rd_i | input | 1 | 1 = target drives (read), 0 = host drives (write) |
| nbits_i | input | 7 | Bits in the command, 1..64 |
| half_i | input | 8 | System clocks per half link period (0 acts as 1) |
| wdata_i | input | 64 | Write word, LSB sent first |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Captured read word |
| swclk_o | output | 1 | Link clock, idle low |
| swdo_o | output | 1 | Data line output value |
| swdoe_o | output | 1 | Data line output enable |
| swdi_i | input | 1 | Data line input value |

## Verification
If the half-period counter or the period sequencer holds a wrong state, the error shows at the ports at once. Either the `busy_o` length breaks the 2·H·(T+N) rule, or the output enable is wrong on the first rising clock edge of a turnaround or data period. If the write bit index is wrong, the bit seen at the very next rising edge is wrong. The bench's target model changes its bit right after each rising edge, so a capture taken a half period late puts a wrong bit in the word presented with `done_o`. The bench also switches direction between commands to exercise both the turnaround and the no-turnaround paths.

// File: rtl/swd_wire_pkg.sv
package swd_wire_pkg;
  localparam int MAX_BITS = 64;
  typedef enum logic {OWN_HOST = 1'b0, OWN_TGT = 1'b1} owner_e;
endpackage

// File: rtl/swd_half_timer.sv
module swd_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              rise_o,
  output logic              fall_o,
  output logic              sclk_o
);
  logic [HALF_W-1:0] lim_q, cnt_q;
  logic              high_q;
  logic              at_end;

  assign at_end = run_i && (cnt_q == lim_q - 1'b1);
  assign rise_o = at_end && !high_q;
  assign fall_o = at_end && high_q;
  assign sclk_o = high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= HALF_W'(1);
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (load_i) begin
      lim_q  <= (half_i == '0) ? HALF_W'(1) : half_i;
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      high_q <= ~high_q;
    end else if (run_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_half_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_q));
endmodule

// File: rtl/swd_bit_seq.sv
module swd_bit_seq
  import swd_wire_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int TURN_CYC = 1,
  localparam int CNT_W = $clog2(MAX_BITS + 1),
  localparam int IDX_W = $clog2(MAX_BITS),
  localparam int TW    = $clog2(TURN_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             fall_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o,
  output logic             dir_o,
  output logic             data_next_o,
  output logic [IDX_W-1:0] idx_next_o,
  output logic             in_data_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_q_o,
  output logic             last_o
);
  logic             busy_q, done_q, rd_q;
  owner_e           owner_q;
  logic [TW-1:0]    turn_q, turn0, turn_nx;
  logic [IDX_W-1:0] idx_q, idx_nx, nlast_q;
  logic             load, last, adv;

  assign load    = start_i && !busy_q;
  assign turn0   = (owner_q != owner_e'(rd_i)) ? TW'(TURN_CYC) : '0;
  assign last    = busy_q && (turn_q == '0) && (idx_q == nlast_q);
  assign adv     = fall_i && !last;
  assign turn_nx = (turn_q != '0) ? turn_q - 1'b1 : '0;
  assign idx_nx  = (turn_q != '0) ? idx_q : idx_q + 1'b1;

  assign load_o      = load;
  assign step_o      = load || adv;
  assign dir_o       = load ? rd_i : rd_q;
  assign data_next_o = load ? (turn0 == '0) : (turn_nx == '0);
  assign idx_next_o  = load ? '0 : idx_nx;
  assign in_data_o   = busy_q && (turn_q == '0);
  assign idx_o       = idx_q;
  assign rd_q_o      = rd_q;
  assign last_o      = last;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      owner_q <= OWN_HOST;
      turn_q  <= '0;
      idx_q   <= '0;
      nlast_q <= '0;
    end else begin
      done_q <= fall_i && last;
      if (load) begin
        busy_q  <= 1'b1;
        rd_q    <= rd_i;
        owner_q <= owner_e'(rd_i);
        turn_q  <= turn0;
        idx_q   <= '0;
        nlast_q <= IDX_W'(nbits_i - 1'b1);
      end else if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          turn_q <= turn_nx;
          idx_q  <= idx_nx;
        end
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_idx_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= nlast_q));
  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> (busy_q && $stable(rd_q) && $stable(nlast_q)));
endmodule

// File: rtl/swd_shift_path.sv
module swd_shift_path #(
  parameter int MAX_BITS = 64,
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] wdata_i,
  input  logic                step_i,
  input  logic                dir_i,
  input  logic                data_next_i,
  input  logic [IDX_W-1:0]    idx_next_i,
  input  logic                sample_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                swdi_i,
  input  logic                finish_i,
  output logic                swdo_o,
  output logic                swdoe_o,
  output logic [MAX_BITS-1:0] rdata_o
);
  logic [MAX_BITS-1:0] wdata_q, wsrc, cap_q, rdata_q;
  logic                do_q, oe_q, drive;

  assign wsrc  = load_i ? wdata_i : wdata_q;
  assign drive = !dir_i && data_next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
      do_q    <= 1'b0;
      oe_q    <= 1'b1;
    end else begin
      if (load_i) begin
        wdata_q <= wdata_i;
        cap_q   <= '0;
      end
      if (step_i) begin
        oe_q <= drive;
        if (drive) do_q <= wsrc[idx_next_i];
      end
      if (sample_i) cap_q[idx_i] <= swdi_i;
      if (finish_i) rdata_q <= cap_q;
    end
  end

  assign swdo_o  = do_q;
  assign swdoe_o = oe_q;
  assign rdata_o = rdata_q;

  assert_no_drive_on_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> !swdoe_o);
endmodule

// File: rtl/swd_wire_engine.sv
module swd_wire_engine
  import swd_wire_pkg::*;
#(
  parameter int MAX_BITS = swd_wire_pkg::MAX_BITS,
  parameter int HALF_W   = 8,
  parameter int TURN_CYC = 1,
  localparam int CNT_W = $clog2(MAX_BITS + 1),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                rd_i,
  input  logic [CNT_W-1:0]    nbits_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [MAX_BITS-1:0] wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] rdata_o,
  output logic                swclk_o,
  output logic                swdo_o,
  output logic                swdoe_o,
  input  logic                swdi_i
);
  logic             load, step, dir, data_next, in_data, rd_q, last;
  logic             rise, fall;
  logic [IDX_W-1:0] idx_next, idx;

  swd_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .run_i(busy_o), .half_i,
    .rise_o(rise), .fall_o(fall), .sclk_o(swclk_o)
  );

  swd_bit_seq #(.MAX_BITS(MAX_BITS), .TURN_CYC(TURN_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i, .rd_i, .nbits_i, .fall_i(fall),
    .busy_o, .done_o, .load_o(load), .step_o(step), .dir_o(dir),
    .data_next_o(data_next), .idx_next_o(idx_next), .in_data_o(in_data),
    .idx_o(idx), .rd_q_o(rd_q), .last_o(last)
  );

  swd_shift_path #(.MAX_BITS(MAX_BITS)) u_path (
    .clk_i, .rst_ni, .load_i(load), .wdata_i, .step_i(step), .dir_i(dir),
    .data_next_i(data_next), .idx_next_i(idx_next),
    .sample_i(rise && in_data && rd_q), .idx_i(idx), .swdi_i,
    .finish_i(fall && last && rd_q),
    .swdo_o, .swdoe_o, .rdata_o
  );

  assert_idle_clk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !swclk_o);
  assert_turn_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !in_data) |-> !swdoe_o);
  assert_do_hold_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swclk_o && $past(swclk_o)) |-> $stable(swdo_o));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/sim_swd_wire_engine.sv
`timescale 1ns/100ps
module sim_swd_wire_engine;
  localparam int TURN = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, rd = 1'b0, swdi = 1'b0;
  logic [6:0]  nbits = 7'd1;
  logic [7:0]  half = 8'd1;
  logic [63:0] wdata = '0;
  logic        busy, done, swclk, swdo, swdoe;
  logic [63:0] rdata;

  always #2.5 clk = ~clk;

  swd_wire_engine #(.TURN_CYC(TURN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd), .nbits_i(nbits),
    .half_i(half), .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .swclk_o(swclk), .swdo_o(swdo), .swdoe_o(swdoe), .swdi_i(swdi)
  );

  typedef struct {
    logic        rd;
    logic [63:0] rexp;
    int          dur;
    int          t0;
  } item_t;
  item_t sb_q[$];

  int checks = 0, errors = 0, cyc = 0;
  bit owner_rd = 0;
  bit cur_rd = 0;
  int cur_t = 0, cur_n = 0, rises = 0;
  logic [63:0] cur_w = '0, cur_r = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // watchdog
  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // bus observer and target model
  initial begin
    forever begin
      @(posedge swclk);
      #1;
      begin
        int p, k, j;
        logic held;
        p = rises; rises++;
        if (p < cur_t) chk(swdoe == 1'b0, "R5 oe off in turnaround", swdoe, 0);
        else begin
          k = p - cur_t;
          if (cur_rd) chk(swdoe == 1'b0, "R6 oe off in read data", swdoe, 0);
          else begin
            chk(swdoe == 1'b1, "R6 oe on in write data", swdoe, 1);
            chk(swdo == cur_w[k], "R3 write bit", swdo, cur_w[k]);
          end
        end
        j = p + 1 - cur_t;
        if (cur_rd && j >= 0 && j < cur_n) swdi = cur_r[j];
        else swdi = ~swdi;
        held = swdo;
        forever begin
          @(negedge clk);
          if (!swclk) break;
          if (swdo !== held) chk(0, "R3 bit stable in high half", swdo, held);
        end
      end
    end
  end

  // monitor
  initial begin
    bit prev_done = 0;
    forever begin
      @(negedge clk);
      if (prev_done && done) chk(0, "R7 done single cycle", done, 0);
      if (done) begin
        if (sb_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cyc - it.t0 == it.dur, "R7 busy length", cyc - it.t0, it.dur);
          chk(busy == 1'b0, "R7 busy low at done", busy, 0);
          if (it.rd) chk(rdata == it.rexp, "R4 read word", rdata, it.rexp);
        end
      end
      prev_done = done;
    end
  end

  task automatic run_cmd(input bit r, input int n, input int h, input logic [63:0] w,
                         input logic [63:0] rp, input bit poke);
    item_t it;
    int hh;
    hh = (h == 0) ? 1 : h;
    cur_t = (r != owner_rd) ? TURN : 0;
    owner_rd = r;
    cur_rd = r; cur_n = n; cur_w = w; cur_r = rp; rises = 0;
    if (r && cur_t == 0) swdi = rp[0];
    it.rd = r;
    it.rexp = (n == 64) ? rp : (rp & ((64'd1 << n) - 64'd1));
    it.dur = 2 * hh * (cur_t + n);
    @(negedge clk);
    it.t0 = cyc + 1;
    sb_q.push_back(it);
    start = 1'b1; rd = r; nbits = 7'(n); half = 8'(h); wdata = w;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; rd = ~r; nbits = 7'd3; wdata = ~w;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(swclk == 1'b0, "R2 clock idle low", swclk, 0);
    chk(swdoe == !r, "R6 idle oe follows owner", swdoe, !r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(swclk == 0 && busy == 0 && done == 0, "R1 reset outputs", {swclk, busy, done}, 0);
    chk(swdoe == 1'b1, "R1 reset oe", swdoe, 1);
    chk(rdata == '0, "R1 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(0, 8, 1, 64'hA5, '0, 0);                          // R3 no turnaround
    run_cmd(1, 32, 2, '0, 64'hDEADBEEF, 0);                   // R4 R5 turnaround
    run_cmd(1, 5, 1, '0, 64'hFFFF_FFFF_FFFF_FFF3, 0);         // R4 upper bits zero
    run_cmd(0, 64, 3, 64'h0123_4567_89AB_CDEF, '0, 0);        // R9 max count
    run_cmd(0, 1, 0, 64'h1, '0, 0);                           // R2 half 0 -> 1, R9 min
    run_cmd(1, 64, 1, '0, 64'hF0E1_D2C3_B4A5_9687, 0);        // R9 max read
    run_cmd(1, 1, 2, '0, 64'h1, 0);                           // R9 min read
    run_cmd(0, 16, 2, 64'h3C5A, '0, 1);                       // R8 start while busy
    run_cmd(0, 12, 1, 64'h9D1, '0, 0);
    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all commands completed", sb_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule